// File: doc/BRIEF.md
# Multi-Threshold Pulse Shape Timestamper

This block records the shape of one analog pulse at a time, as seen through a ladder of comparators whose thresholds rise in magnitude. Each comparator bit arrives already synchronized to the clock of a free-running wide counter. Threshold 0 is the lowest level and acts as the pulse trigger. The counter value at the cycle where threshold 0 first reads high becomes the pulse's absolute timestamp.

The pulse's edges are then recorded in nested order: each higher threshold as it rises, and afterwards each threshold as it falls, from the highest back down to threshold 0. Each edge after the first is stored as a short cycle delta from the edge before it. The pulse ends when threshold 0 falls. At that point the timestamp, the number of thresholds crossed and the packed deltas form one record, which is written into a small FIFO. A processor reads the FIFO through a valid/pop port.

Any threshold above threshold 0 can be switched off. A switched-off threshold is left out of the edge sequence, and it does not disturb the order of the other edges.

Top module: `pulse_shape_stamper`

## Requirements
- R1: A synchronous reset empties the FIFO and returns capture to idle, with `rec_valid_o` and `ovf_o` low.
- R2: The record timestamp is the `count_i` value sampled at the first clock edge where threshold 0 reads high while capture is idle.
- R3: `rec_ncross_o` equals the number of enabled thresholds that rose during the pulse, and it counts threshold 0, so it lies between 1 and NUM_THR. Threshold 0 is always enabled.
- R4: Deltas are recorded in this order: enabled rising edges from the lowest threshold upward, then enabled falling edges from the highest threshold downward. Delta i sits in `rec_delta_o[8i+7:8i]`. A pulse crossing N thresholds fills slots 0 to 2N-2, and the remaining slots read zero.
- R5: Each delta is the number of counter cycles between two consecutive recorded edges.
- R6: A threshold whose enable bit is 0 adds no edge and no delta. A delta that spans it covers the whole interval between the enabled edges on either side.
- R7: A delta larger than 255 cycles is stored as 255.
- R8: The record is written on the clock edge where threshold 0 is seen low, and `rec_valid_o` is high from the next cycle. Records leave in arrival order, and a cycle with `pop_i` high and a valid record removes the head.
- R9: A record that completes while the FIFO holds FIFO_DEPTH records is dropped. `ovf_o` is then high for exactly one cycle, and the stored records are unchanged.
- R10: `pop_i` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | CNT_W (56) | Free-running cycle counter value |
| thr_i | input | NUM_THR (5) | Comparator outputs, bit 0 is the lowest threshold |
| thr_en_i | input | NUM_THR (5) | Per-threshold enable; bit 0 is ignored (always enabled) |
| pop_i | input | 1 | Remove the head record |
| rec_valid_o | output | 1 | FIFO holds at least one record |
| rec_ts_o | output | CNT_W (56) | Head record timestamp |
| rec_ncross_o | output | 3 | Head record threshold count |
| rec_delta_o | output | (2*NUM_THR-1)*DLT_W (72) | Head record deltas, slot 0 in the low byte |
| ovf_o | output | 1 | One-cycle pulse when a record was dropped |

## Verification
The assertions assume that the comparators behave like a real nested pulse. At most one enabled rising or falling edge reaches the block in any cycle, enables only change while every comparator is low, and a higher threshold is high only while all lower thresholds are high. The stimulus builds every pulse from a rise spacing and a hold time that are at least one cycle each, so the edges arrive in separate cycles. It changes enables only between pulses, after a cycle with all comparators low. Within those limits the checks cover pulse heights from one to five thresholds, gaps in the enable mask, deltas that clamp, and a FIFO pushed past full and popped while empty.

// File: rtl/pst_pkg.sv
package pst_pkg;
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_e;
endpackage

// File: rtl/pst_edge.sv
module pst_edge #(
    parameter int NUM_THR = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] lvl_i,
    output logic [NUM_THR-1:0] rise_o,
    output logic [NUM_THR-1:0] fall_o
);
    logic [NUM_THR-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
        fall_o = ~lvl_i & prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/pst_capture.sv
module pst_capture #(
    parameter int NUM_THR = 5,
    parameter int CNT_W   = 56,
    parameter int DLT_W   = 8,
    localparam int ND     = 2*NUM_THR-1,
    localparam int CW     = $clog2(NUM_THR+1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [NUM_THR-1:0] rise_i,
    input  logic [NUM_THR-1:0] fall_i,
    output logic               push_o,
    output logic [CNT_W-1:0]   ts_o,
    output logic [CW-1:0]      ncross_o,
    output logic [ND*DLT_W-1:0] dl_o
);
    localparam int IW = $clog2(ND+1);
    localparam int PW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;

    typedef struct packed {
        pst_pkg::phase_e      ph;
        logic [CNT_W-1:0]     ts;
        logic [CNT_W-1:0]     last;
        logic [PW-1:0]        peak;
        logic [CW-1:0]        ncross;
        logic [IW-1:0]        idx;
        logic [ND*DLT_W-1:0]  dl;
    } cap_t;

    cap_t s_d, s_q;
    logic [CNT_W-1:0] diff;
    logic [DLT_W-1:0] dsat;
    logic             ev, rose, done;
    logic [PW-1:0]    hi;

    always_comb begin
        s_d  = s_q;
        diff = count_i - s_q.last;
        dsat = (|diff[CNT_W-1:DLT_W]) ? '1 : diff[DLT_W-1:0];
        ev   = 1'b0;
        rose = 1'b0;
        hi   = s_q.peak;
        done = 1'b0;
        for (int k = 1; k < NUM_THR; k++) begin
            if (rise_i[k] && (PW'(k) > s_q.peak)) begin
                ev   = 1'b1;
                rose = 1'b1;
                hi   = PW'(k);
            end
            if (fall_i[k]) ev = 1'b1;
        end
        if (fall_i[0]) begin
            ev   = 1'b1;
            done = 1'b1;
        end
        if (s_q.ph == pst_pkg::PH_IDLE) begin
            if (rise_i[0]) begin
                s_d.ph     = pst_pkg::PH_ACTIVE;
                s_d.ts     = count_i;
                s_d.last   = count_i;
                s_d.peak   = '0;
                s_d.ncross = CW'(1);
                s_d.idx    = '0;
                s_d.dl     = '0;
            end
        end else if (ev) begin
            if (s_q.idx < IW'(ND)) begin
                s_d.dl[int'(s_q.idx)*DLT_W +: DLT_W] = dsat;
                s_d.idx = s_q.idx + IW'(1);
            end
            s_d.last = count_i;
            if (rose) begin
                s_d.peak   = hi;
                s_d.ncross = s_q.ncross + CW'(1);
            end
            if (done) s_d.ph = pst_pkg::PH_IDLE;
        end
        push_o   = (s_q.ph == pst_pkg::PH_ACTIVE) && done;
        ts_o     = s_d.ts;
        ncross_o = s_d.ncross;
        dl_o     = s_d.dl;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R4
    single_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({rise_i, fall_i}) <= 1);
    // R3
    ncross_range_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.ph == pst_pkg::PH_ACTIVE) |-> (s_q.ncross >= CW'(1) && s_q.ncross <= CW'(NUM_THR)));
    // R4
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.idx <= IW'(ND));
    // R8
    push_active_chk: assert property (@(posedge clk) disable iff (rst)
        push_o |=> (s_q.ph == pst_pkg::PH_IDLE));
endmodule

// File: rtl/pst_fifo.sv
module pst_fifo #(
    parameter int RW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [RW-1:0] din_i,
    input  logic          pop_i,
    output logic          valid_o,
    output logic [RW-1:0] dout_o,
    output logic          ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [NW-1:0] cnt;
        logic          ovf;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [RW-1:0] mem_q [DEPTH];
    logic full, wr, rd;

    always_comb begin
        c_d   = c_q;
        full  = (c_q.cnt == NW'(DEPTH));
        wr    = push_i && !full;
        rd    = pop_i && (c_q.cnt != '0);
        c_d.ovf = push_i && full;
        if (wr) c_d.wp = (c_q.wp == AW'(DEPTH-1)) ? '0 : c_q.wp + AW'(1);
        if (rd) c_d.rp = (c_q.rp == AW'(DEPTH-1)) ? '0 : c_q.rp + AW'(1);
        c_d.cnt = c_q.cnt + NW'(wr) - NW'(rd);
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        if (wr) mem_q[c_q.wp] <= din_i;
    end

    assign valid_o = (c_q.cnt != '0);
    assign dout_o  = mem_q[c_q.rp];
    assign ovf_o   = c_q.ovf;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        c_q.cnt <= NW'(DEPTH));
    // R9
    drop_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && full && !pop_i) |=> (c_q.cnt == NW'(DEPTH)));
    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !valid_o && !push_i) |=> !valid_o);
    // R9
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> $past(push_i));
endmodule

// File: rtl/pulse_shape_stamper.sv
module pulse_shape_stamper #(
    parameter int NUM_THR    = 5,
    parameter int CNT_W      = 56,
    parameter int DLT_W      = 8,
    parameter int FIFO_DEPTH = 4,
    localparam int ND        = 2*NUM_THR-1,
    localparam int CW        = $clog2(NUM_THR+1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [NUM_THR-1:0]  thr_i,
    input  logic [NUM_THR-1:0]  thr_en_i,
    input  logic                pop_i,
    output logic                rec_valid_o,
    output logic [CNT_W-1:0]    rec_ts_o,
    output logic [CW-1:0]       rec_ncross_o,
    output logic [ND*DLT_W-1:0] rec_delta_o,
    output logic                ovf_o
);
    localparam int RW = CNT_W + CW + ND*DLT_W;

    logic [NUM_THR-1:0] lvl, rise, fall;
    logic               push;
    logic [CNT_W-1:0]   ts;
    logic [CW-1:0]      ncross;
    logic [ND*DLT_W-1:0] dl;
    logic [RW-1:0]      head;

    generate
        if (NUM_THR > 1) begin : g_mask
            assign lvl = thr_i & {thr_en_i[NUM_THR-1:1], 1'b1};
        end else begin : g_single
            assign lvl = thr_i;
        end
    endgenerate

    pst_edge #(.NUM_THR(NUM_THR)) u_edge (
        .clk(clk), .rst(rst), .lvl_i(lvl), .rise_o(rise), .fall_o(fall)
    );

    pst_capture #(.NUM_THR(NUM_THR), .CNT_W(CNT_W), .DLT_W(DLT_W)) u_cap (
        .clk(clk), .rst(rst), .count_i(count_i), .rise_i(rise), .fall_i(fall),
        .push_o(push), .ts_o(ts), .ncross_o(ncross), .dl_o(dl)
    );

    pst_fifo #(.RW(RW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(push), .din_i({ts, ncross, dl}),
        .pop_i(pop_i), .valid_o(rec_valid_o), .dout_o(head), .ovf_o(ovf_o)
    );

    assign {rec_ts_o, rec_ncross_o, rec_delta_o} = head;

    // R8
    valid_after_push_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid_o) |-> $past(push));
endmodule

// File: tb/pulse_shape_stamper_bench.sv
module pulse_shape_stamper_bench;
    localparam int NT = 5;
    localparam int ND = 2*NT-1;
    localparam int DEPTH = 4;
    localparam int NV = 7;
    // en mask, peak threshold count, rise spacing, hold
    localparam int VEC [NV][4] = '{
        '{31, 5, 3, 4},
        '{31, 1, 1, 7},
        '{31, 3, 2, 2},
        '{21, 5, 2, 3},
        '{31, 2, 100, 300},
        '{27, 4, 1, 1},
        '{1,  3, 2, 2}
    };

    logic clk = 0, rst = 1, pop_i = 0;
    logic [55:0] count_i = '0;
    logic [NT-1:0] thr_i = '0, thr_en_i = '1;
    logic rec_valid_o, ovf_o;
    logic [55:0] rec_ts_o;
    logic [2:0] rec_ncross_o;
    logic [ND*8-1:0] rec_delta_o;

    int checks = 0, failures = 0;
    bit done = 0;
    longint cnt = 0;

    always #5 clk = ~clk;

    pulse_shape_stamper u_pulse_shape_stamper (
        .clk(clk), .rst(rst), .count_i(count_i), .thr_i(thr_i), .thr_en_i(thr_en_i),
        .pop_i(pop_i), .rec_valid_o(rec_valid_o), .rec_ts_o(rec_ts_o),
        .rec_ncross_o(rec_ncross_o), .rec_delta_o(rec_delta_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [NT-1:0] t);
        @(negedge clk);
        cnt++;
        count_i = cnt[55:0];
        thr_i = t;
    endtask

    task automatic do_pop();
        @(negedge clk); pop_i = 1;
        @(negedge clk); pop_i = 0;
    endtask

    // Applies one nested pulse and computes the expected record.
    task automatic pulse(input int en, input int p, input int g, input int h,
                         output longint t0, output int ncr, output logic [ND*8-1:0] dl);
        int tend, fk, n;
        longint et [2*NT];
        logic [NT-1:0] m;
        thr_en_i = en[NT-1:0];
        drive('0);
        tend = 2*(p-1)*g + h;
        t0 = cnt + 1;
        for (int t = 0; t <= tend; t++) begin
            m = '0;
            for (int k = 0; k < p; k++) begin
                fk = (p-1)*g + h + (p-1-k)*g;
                if (t >= k*g && t < fk) m[k] = 1'b1;
            end
            drive(m);
        end
        n = 0; ncr = 0;
        for (int k = 0; k < p; k++)
            if (k == 0 || en[k]) begin et[n] = t0 + k*g; n++; ncr++; end
        for (int k = p-1; k >= 0; k--)
            if (k == 0 || en[k]) begin et[n] = t0 + (p-1)*g + h + (p-1-k)*g; n++; end
        dl = '0;
        for (int i = 0; i < n-1; i++)
            dl[i*8 +: 8] = (et[i+1]-et[i] > 255) ? 8'hFF : 8'(et[i+1]-et[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        longint t0, ts[DEPTH+1];
        int ncr;
        logic [ND*8-1:0] dl;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", rec_valid_o, 0);
        chk("R1 ovf", ovf_o, 0);
        rst = 0;

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            pulse(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], t0, ncr, dl);
            @(negedge clk);
            chk("R8 valid", rec_valid_o, 1);
            chk("R2 ts", rec_ts_o, t0);
            chk("R3 R6 ncross", rec_ncross_o, ncr);
            chk("R4 R5 R6 R7 deltas", rec_delta_o, dl);
            chk("R9 no ovf", ovf_o, 0);
            do_pop();
            chk("R8 pop empties", rec_valid_o, 0);
        end

        // R9 overflow: DEPTH+1 pulses without popping
        for (int i = 0; i <= DEPTH; i++) begin
            pulse(31, 1, 1, 2, ts[i], ncr, dl);
            @(negedge clk);
            chk("R9 ovf flag", ovf_o, (i == DEPTH));
        end
        @(negedge clk);
        chk("R9 ovf one cycle", ovf_o, 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R8 R9 order", rec_ts_o, ts[i]);
            do_pop();
        end
        chk("R9 dropped record absent", rec_valid_o, 0);

        // R10 pop while empty
        do_pop();
        chk("R10 still empty", rec_valid_o, 0);
        pulse(31, 2, 2, 3, t0, ncr, dl);
        @(negedge clk);
        chk("R10 ts after empty pop", rec_ts_o, t0);
        do_pop();
        chk("R10 single record", rec_valid_o, 0);

        // R1 reset mid-run clears stored record
        pulse(31, 1, 1, 2, t0, ncr, dl);
        @(negedge clk);
        chk("R1 stored before reset", rec_valid_o, 1);
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 cleared", rec_valid_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule